// File: doc/BRIEF.md
# Fixed-Point Format Cast Unit

This unit converts a fixed-point number from one format to another, as a datapath stage next to element-wise arithmetic such as scale-and-shift or residual adds. Each format is given at run time as a word length and an integer length. The fraction length is the word length minus the integer length, so the binary point may move left or right during the cast. Both the source and the target can be signed (two's complement) or unsigned.

The cast has two steps. When the target keeps fewer fraction bits than the source, a selectable rounding rule drops the extra fraction bits. A selectable overflow rule then fits the rounded value into the target range: it can clamp, force zero, clamp symmetrically, or keep the low bits. The aim is a bit-exact match with the usual arbitrary-precision fixed-point type semantics of high-level synthesis. An overflow flag reports whether the rounded value fell outside the target range, whatever rule was applied. The result and the flag are registered, so they appear one clock after the operands.

Top module: `fxcast_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res` and `ovf` are cleared to zero on that edge.
- R2: The source value is the low `in_wl` bits of `din`, where 1 <= `in_il` <= ... is not required but `0 <= in_il <= in_wl` is. It is two's complement when `in_signed` is 1 and unsigned otherwise. Bits of `din` at position `in_wl` and above have no effect on the outputs.
- R3: `res` and `ovf` reflect the operands sampled at the previous rising edge. The target value sits in the low `out_wl` bits of `res`, with 1 <= `out_wl` <= 16 and 0 <= `out_il` <= `out_wl`. It is sign-extended to the full width when `out_signed` is 1 and zero-extended otherwise.
- R4: When the target fraction length (`out_wl - out_il`) is at least the source fraction length, the value is scaled exactly and no rounding takes place.
- R5: When fraction bits are dropped, `rmode` selects the rule. Code 0 rounds to nearest with ties toward +inf. Code 1 rounds to nearest with ties toward zero. Code 2 rounds to nearest with ties toward -inf. Code 3 rounds to nearest with ties away from zero. Code 5 floors toward -inf. Code 6 truncates toward zero. Code 7 behaves like code 5.
- R6: With `rmode` code 4, a value nearer to one neighbour goes to that neighbour, and an exact tie goes to the neighbour with an even integer.
- R7: `ovf` is 1 exactly when the rounded value lies outside the target range, for every overflow rule. The range is [-2^(out_wl-1), 2^(out_wl-1)-1] when signed and [0, 2^out_wl-1] when unsigned.
- R8: With `omode` code 0, an out-of-range value becomes the target maximum or minimum, whichever side it left on.
- R9: With `omode` code 1, an out-of-range value gives a result of zero.
- R10: With `omode` code 2 and a signed target, a value below the range becomes minus the maximum, and a value above the range becomes the maximum. For an unsigned target, code 2 behaves like code 0.
- R11: With `omode` code 3, the result is the low `out_wl` bits of the rounded value, read as signed or unsigned according to `out_signed`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Source data, right-aligned |
| in_wl | input | 5 | Source word length |
| in_il | input | 5 | Source integer length |
| in_signed | input | 1 | Source is two's complement |
| out_wl | input | 5 | Target word length |
| out_il | input | 5 | Target integer length |
| out_signed | input | 1 | Target is two's complement |
| rmode | input | 3 | Rounding rule code |
| omode | input | 2 | Overflow rule code |
| res | output | 16 | Cast result, extended to full width |
| ovf | output | 1 | Rounded value was out of target range |

## Verification
Some rules hold on every cycle, and the assertions check those. They check the reset clearing, the zero extension of unsigned results, the zero result on overflow under the zeroing rule, the clamp to an end of the range under the clamping rule, and that symmetric clamping never yields the most negative code. The exact numeric value of a cast can only be shown by the bench's scenarios, which compare against an integer model. That covers how each tie is broken, the exact left scaling, the wrapped bit patterns, and that stray high input bits are ignored. The scenarios mix random formats and modes with directed half-way values of both signs.

// File: rtl/fxcast_pkg.sv
package fxcast_pkg;

    typedef enum logic [2:0] {
        RM_HALF_UP   = 3'd0,
        RM_HALF_ZERO = 3'd1,
        RM_HALF_DOWN = 3'd2,
        RM_HALF_AWAY = 3'd3,
        RM_HALF_EVEN = 3'd4,
        RM_FLOOR     = 3'd5,
        RM_TOZERO    = 3'd6
    } rnd_mode_e;

    typedef enum logic [1:0] {
        OV_CLAMP = 2'd0,
        OV_ZERO  = 2'd1,
        OV_SYM   = 2'd2,
        OV_WRAP  = 2'd3
    } ovf_mode_e;

    // Information about the discarded fraction bits.
    typedef struct packed {
        logic half;    // weight of one half LSB of the target
        logic sticky;  // any bit below the half position
        logic neg;     // source value is negative
    } rem_bits_t;

    // Decide whether the floored value must be incremented.
    function automatic logic round_inc(input logic [2:0] mode,
                                       input rem_bits_t rb,
                                       input logic lsb);
        logic inc;
        case (mode)
            RM_HALF_UP:   inc = rb.half;
            RM_HALF_ZERO: inc = rb.half & (rb.sticky | rb.neg);
            RM_HALF_DOWN: inc = rb.half & rb.sticky;
            RM_HALF_AWAY: inc = rb.half & (rb.sticky | ~rb.neg);
            RM_HALF_EVEN: inc = rb.half & (rb.sticky | lsb);
            RM_TOZERO:    inc = rb.neg & (rb.half | rb.sticky);
            default:      inc = 1'b0;
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/fxcast_align.sv
module fxcast_align
    import fxcast_pkg::*;
#(
    parameter int DW  = 16,
    parameter int WLW = 5,
    parameter int IW  = 2 * DW + 2
) (
    input  logic [DW-1:0]          din,
    input  logic [WLW-1:0]         in_wl,
    input  logic [WLW-1:0]         in_il,
    input  logic                   in_signed,
    input  logic [WLW-1:0]         out_wl,
    input  logic [WLW-1:0]         out_il,
    output logic signed [IW-1:0]   base,
    output rem_bits_t              rb
);
    localparam int SW = WLW + 2;
    localparam logic [IW-1:0] ONE = {{(IW-1){1'b0}}, 1'b1};

    logic                 msb;
    logic                 fill;
    logic signed [IW-1:0] ext;
    logic signed [SW-1:0] frac_in;
    logic signed [SW-1:0] frac_out;
    logic signed [SW-1:0] sdiff;
    logic [IW-1:0]        half_mask;

    always_comb begin
        msb = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i == int'(in_wl) - 1) msb = din[i];
        end
        fill = in_signed & msb;
        ext  = '0;
        for (int i = 0; i < IW; i++) begin
            if (i < DW && i < int'(in_wl)) ext[i] = din[i];
            else                           ext[i] = fill;
        end
    end

    assign frac_in  = SW'(in_wl) - SW'(in_il);
    assign frac_out = SW'(out_wl) - SW'(out_il);
    assign sdiff    = frac_in - frac_out;

    always_comb begin
        rb.neg    = fill;
        rb.half   = 1'b0;
        rb.sticky = 1'b0;
        half_mask = '0;
        if (sdiff <= 0) begin
            base = ext <<< int'(-sdiff);
        end else begin
            base      = ext >>> int'(sdiff);
            half_mask = ONE << (int'(sdiff) - 1);
            rb.half   = |(ext & half_mask);
            rb.sticky = |(ext & (half_mask - ONE));
        end
    end

endmodule

// File: rtl/fxcast_round.sv
module fxcast_round
    import fxcast_pkg::*;
#(
    parameter int IW = 34
) (
    input  logic signed [IW-1:0] base,
    input  rem_bits_t            rb,
    input  logic [2:0]           rmode,
    output logic signed [IW-1:0] rounded
);
    logic inc;

    assign inc     = round_inc(rmode, rb, base[0]);
    assign rounded = base + $signed({{(IW-1){1'b0}}, inc});

endmodule

// File: rtl/fxcast_limit.sv
module fxcast_limit
    import fxcast_pkg::*;
#(
    parameter int DW  = 16,
    parameter int WLW = 5,
    parameter int IW  = 2 * DW + 2
) (
    input  logic signed [IW-1:0] rounded,
    input  logic [WLW-1:0]       out_wl,
    input  logic                 out_signed,
    input  logic [1:0]           omode,
    output logic [DW-1:0]        res_n,
    output logic                 ovf_n
);
    localparam logic signed [IW-1:0] ONE = {{(IW-1){1'b0}}, 1'b1};

    logic signed [IW-1:0] hi;
    logic signed [IW-1:0] lo;
    logic signed [IW-1:0] wmask;
    logic signed [IW-1:0] wrapped;
    logic signed [IW-1:0] sel;
    logic                 above;
    logic                 below;

    always_comb begin
        if (out_signed) begin
            hi = (ONE <<< (int'(out_wl) - 1)) - ONE;
            lo = -(ONE <<< (int'(out_wl) - 1));
        end else begin
            hi = (ONE <<< int'(out_wl)) - ONE;
            lo = '0;
        end
    end

    assign above = rounded > hi;
    assign below = rounded < lo;
    assign ovf_n = above | below;

    always_comb begin
        wmask   = (ONE <<< int'(out_wl)) - ONE;
        wrapped = rounded & wmask;
        if (out_signed && (wrapped & (ONE <<< (int'(out_wl) - 1))) != '0)
            wrapped = wrapped | ~wmask;
    end

    always_comb begin
        case (ovf_mode_e'(omode))
            OV_CLAMP: sel = above ? hi : (below ? lo : rounded);
            OV_ZERO:  sel = ovf_n ? '0 : rounded;
            OV_SYM:   sel = above ? hi : (below ? (out_signed ? -hi : lo) : rounded);
            default:  sel = wrapped;
        endcase
    end

    assign res_n = sel[DW-1:0];

endmodule

// File: rtl/fxcast_unit.sv
module fxcast_unit
    import fxcast_pkg::*;
#(
    parameter int DW      = 16,
    parameter int WLW     = 5,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  din,
    input  logic [WLW-1:0] in_wl,
    input  logic [WLW-1:0] in_il,
    input  logic           in_signed,
    input  logic [WLW-1:0] out_wl,
    input  logic [WLW-1:0] out_il,
    input  logic           out_signed,
    input  logic [2:0]     rmode,
    input  logic [1:0]     omode,
    output logic [DW-1:0]  res,
    output logic           ovf
);
    localparam int IW = 2 * DW + 2;

    logic signed [IW-1:0] base;
    logic signed [IW-1:0] rounded;
    rem_bits_t            rb;
    logic [DW-1:0]        res_n;
    logic                 ovf_n;

    fxcast_align #(.DW(DW), .WLW(WLW), .IW(IW)) u_align (
        .din       (din),
        .in_wl     (in_wl),
        .in_il     (in_il),
        .in_signed (in_signed),
        .out_wl    (out_wl),
        .out_il    (out_il),
        .base      (base),
        .rb        (rb)
    );

    fxcast_round #(.IW(IW)) u_round (
        .base    (base),
        .rb      (rb),
        .rmode   (rmode),
        .rounded (rounded)
    );

    fxcast_limit #(.DW(DW), .WLW(WLW), .IW(IW)) u_limit (
        .rounded    (rounded),
        .out_wl     (out_wl),
        .out_signed (out_signed),
        .omode      (omode),
        .res_n      (res_n),
        .ovf_n      (ovf_n)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    res <= '0;
                    ovf <= 1'b0;
                end else begin
                    res <= res_n;
                    ovf <= ovf_n;
                end
            end
        end else begin : g_comb
            assign res = res_n;
            assign ovf = ovf_n;
        end
    endgenerate

endmodule

// File: rtl/fxcast_chk.sv
module fxcast_chk #(
    parameter int DW      = 16,
    parameter int WLW     = 5,
    parameter bit OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           rst,
    input logic [WLW-1:0] out_wl,
    input logic           out_signed,
    input logic [1:0]     omode,
    input logic [DW-1:0]  res,
    input logic           ovf
);
    localparam logic [DW-1:0] ALL1 = {DW{1'b1}};

    logic [WLW-1:0] p_wl;
    logic           p_sg;
    logic [DW-1:0]  max_pat;
    logic [DW-1:0]  min_pat;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_wl <= '0;
            p_sg <= 1'b0;
        end else begin
            p_wl <= out_wl;
            p_sg <= out_signed;
        end
    end

    always_comb begin
        if (p_sg) begin
            max_pat = ALL1 >> (DW - int'(p_wl) + 1);
            min_pat = ALL1 << (int'(p_wl) - 1);
        end else begin
            max_pat = ALL1 >> (DW - int'(p_wl));
            min_pat = '0;
        end
    end

    generate
        if (OUT_REG) begin : g_props
            // R1
            reset_clear_chk: assert property (@(posedge clk)
                rst |=> (res == '0 && !ovf));

            // R3
            unsigned_ext_chk: assert property (@(posedge clk) disable iff (rst)
                (!out_signed && out_wl >= 1) |=> ((res >> p_wl) == '0));

            // R9
            zero_on_ovf_chk: assert property (@(posedge clk) disable iff (rst)
                (omode == 2'd1) |=> (!ovf || res == '0));

            // R8
            clamp_end_chk: assert property (@(posedge clk) disable iff (rst)
                (omode == 2'd0 && out_wl >= 1) |=> (!ovf || res == max_pat || res == min_pat));

            // R10
            sym_no_min_chk: assert property (@(posedge clk) disable iff (rst)
                (omode == 2'd2 && out_signed && out_wl >= 2) |=> (!ovf || res != min_pat));
        end
    endgenerate

endmodule

bind fxcast_unit fxcast_chk #(.DW(DW), .WLW(WLW), .OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_wl     (out_wl),
    .out_signed (out_signed),
    .omode      (omode),
    .res        (res),
    .ovf        (ovf)
);

// File: tb/fxcast_unit_bench.sv
`timescale 1ns/1ps
module fxcast_unit_bench;
    localparam int DW  = 16;
    localparam int WLW = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [DW-1:0]  din = '0;
    logic [WLW-1:0] in_wl = 5'd8;
    logic [WLW-1:0] in_il = 5'd8;
    logic           in_signed = 1'b0;
    logic [WLW-1:0] out_wl = 5'd8;
    logic [WLW-1:0] out_il = 5'd8;
    logic           out_signed = 1'b0;
    logic [2:0]     rmode = '0;
    logic [1:0]     omode = '0;
    logic [DW-1:0]  res;
    logic           ovf;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    fxcast_unit #(.DW(DW), .WLW(WLW)) u_fxcast_unit (
        .clk(clk), .rst(rst), .din(din), .in_wl(in_wl), .in_il(in_il),
        .in_signed(in_signed), .out_wl(out_wl), .out_il(out_il),
        .out_signed(out_signed), .rmode(rmode), .omode(omode),
        .res(res), .ovf(ovf)
    );

    // Integer model of the cast, written from the requirements.
    function automatic void model(input logic [DW-1:0] d, input int iw, input int ii,
                                  input bit is, input int ow, input int oi, input bit os,
                                  input int rm, input int om,
                                  output logic [DW-1:0] er, output bit eo);
        longint x, q, r, dv, rv, hi, lo, w, m, v;
        bit gt, eq, neg, any;
        int fi, fo;
        x = longint'(d) & ((longint'(1) << iw) - 1);
        if (is && ((x >> (iw - 1)) & 1) == 1) x = x - (longint'(1) << iw);
        fi = iw - ii;
        fo = ow - oi;
        if (fo >= fi) begin
            rv = x * (longint'(1) << (fo - fi));
        end else begin
            dv = longint'(1) << (fi - fo);
            q = x / dv;
            if (x < 0 && q * dv != x) q = q - 1;
            r = x - q * dv;
            gt = (2 * r) > dv;
            eq = (2 * r) == dv;
            any = r != 0;
            neg = x < 0;
            case (rm)
                0: rv = q + longint'(gt || eq);
                1: rv = q + longint'(gt || (eq && neg));
                2: rv = q + longint'(gt);
                3: rv = q + longint'(gt || (eq && !neg));
                4: rv = q + longint'(gt || (eq && ((q & 1) != 0)));
                6: rv = q + longint'(neg && any);
                default: rv = q;
            endcase
        end
        if (os) begin
            hi = (longint'(1) << (ow - 1)) - 1;
            lo = -(longint'(1) << (ow - 1));
        end else begin
            hi = (longint'(1) << ow) - 1;
            lo = 0;
        end
        eo = (rv > hi) || (rv < lo);
        m = (longint'(1) << ow) - 1;
        w = rv & m;
        if (os && w > hi) w = w - (longint'(1) << ow);
        case (om)
            0: v = (rv > hi) ? hi : ((rv < lo) ? lo : rv);
            1: v = eo ? 0 : rv;
            2: v = (rv > hi) ? hi : ((rv < lo) ? (os ? -hi : lo) : rv);
            default: v = w;
        endcase
        er = v[DW-1:0];
    endfunction

    function automatic string rtag(input int rm, input int iw, input int ii,
                                   input int ow, input int oi);
        if (ow - oi >= iw - ii) return "R4";
        if (rm == 4) return "R6";
        return "R5";
    endfunction

    function automatic string otag(input int om);
        case (om)
            0: return "R8";
            1: return "R9";
            2: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Apply one vector at a falling edge, check it at the next falling edge.
    task automatic run(input logic [DW-1:0] d, input int iw, input int ii, input bit is,
                       input int ow, input int oi, input bit os, input int rm, input int om,
                       input string extra);
        logic [DW-1:0] er;
        bit eo;
        din = d; in_wl = WLW'(iw); in_il = WLW'(ii); in_signed = is;
        out_wl = WLW'(ow); out_il = WLW'(oi); out_signed = os;
        rmode = 3'(rm); omode = 2'(om);
        model(d, iw, ii, is, ow, oi, os, rm, om, er, eo);
        @(negedge clk);
        n_tests++;
        if (res !== er || ovf !== eo) begin
            n_fail++;
            $display("FAIL %s %s R7 R3 %s: din=%h in=%0d.%0d/%0b out=%0d.%0d/%0b rm=%0d om=%0d res=%h exp=%h ovf=%0b exp=%0b",
                     rtag(rm, iw, ii, ow, oi), otag(om), extra, d, iw, ii, is, ow, oi, os,
                     rm, om, res, er, ovf, eo);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1: outputs cleared during reset
        n_tests++;
        if (res !== '0 || ovf !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset res=%h exp=0000 ovf=%0b exp=0", res, ovf);
        end
        rst = 1'b0;

        // R5 R6: exact ties of both signs, 2.5 / -2.5 / 1.5 / -1.5, every rounding code
        for (int rm = 0; rm < 8; rm++) begin
            run(16'h0005, 8, 7, 1'b1, 8, 8, 1'b1, rm, 0, "tie+2.5");
            run(16'h00FB, 8, 7, 1'b1, 8, 8, 1'b1, rm, 0, "tie-2.5");
            run(16'h0003, 8, 7, 1'b1, 8, 8, 1'b1, rm, 0, "tie+1.5");
            run(16'h00FD, 8, 7, 1'b1, 8, 8, 1'b1, rm, 0, "tie-1.5");
            run(16'h002B, 8, 4, 1'b1, 8, 6, 1'b1, rm, 0, "near");
        end
        // R2: garbage above the source word is ignored
        run(16'hAB05, 8, 7, 1'b1, 8, 8, 1'b1, 0, 0, "R2 upper bits");
        run(16'h5A85, 8, 8, 1'b0, 12, 12, 1'b0, 5, 0, "R2 upper bits");
        // R4: exact left scaling
        run(16'h00FD, 8, 8, 1'b1, 12, 6, 1'b1, 0, 0, "R4 scale");
        // R7 with every overflow rule, signed and unsigned targets
        for (int om = 0; om < 4; om++) begin
            run(16'h007F, 8, 8, 1'b1, 4, 4, 1'b1, 0, om, "pos over");
            run(16'h0080, 8, 8, 1'b1, 4, 4, 1'b1, 0, om, "neg over");
            run(16'h0080, 8, 8, 1'b1, 4, 4, 1'b0, 0, om, "neg to unsigned");
            run(16'h00F8, 8, 8, 1'b1, 4, 4, 1'b1, 0, om, "min in range");
            run(16'h00FF, 8, 8, 1'b0, 4, 4, 1'b0, 5, om, "unsigned over");
        end
        // Random formats and modes
        for (int k = 0; k < 4000; k++) begin
            int iw, ii, ow, oi;
            iw = int'($urandom_range(16, 1));
            ii = int'($urandom_range(iw, 0));
            ow = int'($urandom_range(16, 1));
            oi = int'($urandom_range(ow, 0));
            run(16'($urandom), iw, ii, 1'($urandom), ow, oi, 1'($urandom),
                int'($urandom_range(7, 0)), int'($urandom_range(3, 0)), "random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule